// File: doc/BRIEF.md
# Spare Element Remapping Controller

This controller keeps an array of processing elements working after one of them fails. A health monitor outside the block flags broken elements. The controller then moves the role of a broken element onto an element that is currently unused. A run begins with a one-cycle start pulse. At that pulse the controller takes a snapshot of three inputs: the activity mask, the fault mask and the configuration word. The configuration word describes, for every element, its operation and the two places it takes its operands from.

The controller works through the elements one per cycle. First it looks for the broken element that is in use, and it decodes that element's settings. It then makes a second pass to find the nearest usable spare on the row/column grid. In a single cycle it writes back a configuration word in which the spare has taken over the broken element's work. Every element that was fed by the broken element is re-pointed to the spare in the same write. A one-cycle done pulse closes the run. If no usable spare exists, an error flag is raised and nothing is changed.

Top module: `rmp_spare_ctrl`

## Requirements
- R1: Element k (numbered 1 to 25) corresponds to bit 25-k of the activity mask and of the fault mask, so element 1 is the leftmost bit. On the grid it sits at row (k-1) mod 4 and column (k-1) div 4.
- R2: A run handles only the lowest-numbered element that is both in use and faulty. Faults on unused elements are ignored. If no element is both in use and faulty, the run ends with the configuration and activity outputs equal to the snapshot inputs, err_o low and spare_loc_o zero.
- R3: The spare is an element that is both unused and not faulty. Among those, it is the one at the smallest Manhattan distance from the faulty element, and a tie goes to the lower element number.
- R4: spare_loc_o equals {row[1:0], col[2:0]} of the chosen spare. It is zero when no spare was chosen.
- R5: Element k's setting occupies configuration bits [(k-1)*13 +: 13]: operation code in bits [12:10], operand A source in bits [9:5], operand B source in bits [4:0]. A source code of 0 means an external input, and codes 1 to 25 name an element. After a remap, the spare's setting carries the faulty element's operation code and operand sources.
- R6: After a remap, the faulty element's setting is all zeros.
- R7: After a remap, every operand source in the word that named the faulty element names the spare instead. This includes the sources copied into the spare.
- R8: After a remap, the activity output has the spare's bit set and the faulty element's bit cleared. All other bits equal the snapshot.
- R9: When an in-use faulty element exists but no element is both unused and fault-free, err_o is high when done_o pulses. The configuration and activity outputs then equal the snapshot and spare_loc_o is zero.
- R10: done_o is high for exactly one cycle at the end of each run. err_o, spare_loc_o, cfg_o and act_mask_o hold their values after the pulse until the next start.
- R11: During reset, done_o, err_o, spare_loc_o, cfg_o and act_mask_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a run (only sampled when idle) |
| act_mask_i | input | 25 | Elements in use, 1 = in use |
| flt_mask_i | input | 25 | Elements reported faulty |
| cfg_i | input | 325 | Configuration word to repair |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | No usable spare was found |
| spare_loc_o | output | 5 | Row and column of the chosen spare |
| cfg_o | output | 325 | Repaired configuration word |
| act_mask_o | output | 25 | Updated activity mask |

## Verification
The bench builds the block with its default values: 25 elements on a grid of 4 rows. The bench sweeps a single fault over every one of the 25 elements under a fixed mask. This reaches both edges of the grid, element 25 alone in the last column, and faults that land on unused elements. Crafted masks add a distance tie, a fully busy array and a faulty spare candidate. Many pseudo-random masks and configuration words then exercise the re-pointing of consumers across fields.

// File: rtl/rmp_pkg.sv
// Shared types for the spare remapping controller.
package rmp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DECODE,
        ST_SELECT,
        ST_REWRITE,
        ST_DONE
    } rmp_state_e;
endpackage

// File: rtl/rmp_grid_pos.sv
// Converts a 1-based element number into its grid row and column.
// Assumes elements fill the grid column by column, GRID_ROWS per column.
module rmp_grid_pos #(
    parameter int NUM_PE    = 25,
    parameter int GRID_ROWS = 4,
    localparam int IDX_W     = $clog2(NUM_PE + 1),
    localparam int GRID_COLS = (NUM_PE + GRID_ROWS - 1) / GRID_ROWS,
    localparam int ROW_W     = (GRID_ROWS > 1) ? $clog2(GRID_ROWS) : 1,
    localparam int COL_W     = (GRID_COLS > 1) ? $clog2(GRID_COLS) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    int zidx;

    // zero-based position split into row and column
    always_comb begin
        zidx  = (idx_i == '0) ? 0 : int'(idx_i) - 1;
        row_o = ROW_W'(zidx % GRID_ROWS);
        col_o = COL_W'(zidx / GRID_ROWS);
    end
endmodule

// File: rtl/rmp_cfg_rewrite.sv
// Builds the repaired configuration word in one pass over all fields:
// the spare receives the faulty element's setting, sources naming the
// faulty element are re-pointed to the spare, the faulty field is zeroed.
// Assumes flt_idx_i and spr_idx_i are distinct and non-zero when used.
module rmp_cfg_rewrite #(
    parameter int NUM_PE = 25,
    parameter int FUNC_W = 3,
    localparam int IDX_W = $clog2(NUM_PE + 1),
    localparam int FLD_W = FUNC_W + 2 * IDX_W,
    localparam int CFG_W = NUM_PE * FLD_W
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [FLD_W-1:0] flt_fld_i,
    input  logic [IDX_W-1:0] flt_idx_i,
    input  logic [IDX_W-1:0] spr_idx_i,
    output logic [CFG_W-1:0] cfg_o
);
    for (genvar g = 0; g < NUM_PE; g++) begin : g_fld
        localparam logic [IDX_W-1:0] ME = IDX_W'(g + 1);
        logic [FLD_W-1:0] base;
        logic [FLD_W-1:0] outf;

        // choose the source setting, then redirect both operand sources
        always_comb begin
            base = (ME == spr_idx_i) ? flt_fld_i : cfg_i[g*FLD_W +: FLD_W];
            outf = base;
            if (base[2*IDX_W-1 -: IDX_W] == flt_idx_i)
                outf[2*IDX_W-1 -: IDX_W] = spr_idx_i;
            if (base[IDX_W-1:0] == flt_idx_i)
                outf[IDX_W-1:0] = spr_idx_i;
            if (ME == flt_idx_i)
                outf = '0;
        end

        assign cfg_o[g*FLD_W +: FLD_W] = outf;
    end
endmodule

// File: rtl/rmp_spare_ctrl.sv
// Spare remapping controller. On start it snapshots the masks and the
// configuration word, scans serially for the lowest in-use faulty element,
// decodes its field, scans again for the nearest unused fault-free spare
// (Manhattan distance, lower number wins ties), then rewrites the word and
// the activity mask in one cycle. Start is ignored while a run is active.
module rmp_spare_ctrl
    import rmp_pkg::*;
#(
    parameter int NUM_PE    = 25,
    parameter int GRID_ROWS = 4,
    parameter int FUNC_W    = 3,
    localparam int IDX_W     = $clog2(NUM_PE + 1),
    localparam int GRID_COLS = (NUM_PE + GRID_ROWS - 1) / GRID_ROWS,
    localparam int ROW_W     = (GRID_ROWS > 1) ? $clog2(GRID_ROWS) : 1,
    localparam int COL_W     = (GRID_COLS > 1) ? $clog2(GRID_COLS) : 1,
    localparam int LOC_W     = ROW_W + COL_W,
    localparam int DIST_W    = $clog2(GRID_ROWS + GRID_COLS) + 1,
    localparam int FLD_W     = FUNC_W + 2 * IDX_W,
    localparam int CFG_W     = NUM_PE * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NUM_PE-1:0] act_mask_i,
    input  logic [NUM_PE-1:0] flt_mask_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              done_o,
    output logic              err_o,
    output logic [LOC_W-1:0]  spare_loc_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [NUM_PE-1:0] act_mask_o
);
    rmp_state_e        state;
    logic [IDX_W-1:0]  scan_k, flt_idx, spr_idx;
    logic [DIST_W-1:0] best_d, cur_d;
    logic [FLD_W-1:0]  fld_q, flt_fld_w;
    logic [NUM_PE-1:0] act_q, flt_q;
    logic [CFG_W-1:0]  cfg_q, cfg_new;
    logic              err_q;
    logic [LOC_W-1:0]  loc_q;
    logic [IDX_W-1:0]  scan_bit, flt_bit, spr_bit;
    logic [ROW_W-1:0]  f_row, c_row, s_row;
    logic [COL_W-1:0]  f_col, c_col, s_col;
    logic              fault_hit, cand_ok, take_cand;
    int                fld_base;

    rmp_grid_pos #(.NUM_PE(NUM_PE), .GRID_ROWS(GRID_ROWS)) u_pos_flt (
        .idx_i(flt_idx), .row_o(f_row), .col_o(f_col));
    rmp_grid_pos #(.NUM_PE(NUM_PE), .GRID_ROWS(GRID_ROWS)) u_pos_cur (
        .idx_i(scan_k), .row_o(c_row), .col_o(c_col));
    rmp_grid_pos #(.NUM_PE(NUM_PE), .GRID_ROWS(GRID_ROWS)) u_pos_spr (
        .idx_i(spr_idx), .row_o(s_row), .col_o(s_col));

    rmp_cfg_rewrite #(.NUM_PE(NUM_PE), .FUNC_W(FUNC_W)) u_rewrite (
        .cfg_i(cfg_q), .flt_fld_i(fld_q), .flt_idx_i(flt_idx),
        .spr_idx_i(spr_idx), .cfg_o(cfg_new));

    // mask bit positions: element k lives at bit NUM_PE-k
    assign scan_bit = IDX_W'(NUM_PE) - scan_k;
    assign flt_bit  = IDX_W'(NUM_PE) - flt_idx;
    assign spr_bit  = IDX_W'(NUM_PE) - spr_idx;

    // per-element classification and distance for the element being scanned
    always_comb begin
        fault_hit = act_q[scan_bit] && flt_q[scan_bit];
        cand_ok   = !act_q[scan_bit] && !flt_q[scan_bit];
        cur_d     = DIST_W'((f_row > c_row) ? f_row - c_row : c_row - f_row)
                  + DIST_W'((f_col > c_col) ? f_col - c_col : c_col - f_col);
        take_cand = cand_ok && (cur_d < best_d);
        fld_base  = (flt_idx == '0) ? 0 : (int'(flt_idx) - 1) * FLD_W;
        flt_fld_w = cfg_q[fld_base +: FLD_W];
    end

    // sequencer: snapshot, fault scan, decode, spare scan, rewrite, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            scan_k  <= '0;
            flt_idx <= '0;
            spr_idx <= '0;
            best_d  <= '1;
            fld_q   <= '0;
            act_q   <= '0;
            flt_q   <= '0;
            cfg_q   <= '0;
            err_q   <= 1'b0;
            loc_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    act_q   <= act_mask_i;
                    flt_q   <= flt_mask_i;
                    cfg_q   <= cfg_i;
                    scan_k  <= IDX_W'(1);
                    flt_idx <= '0;
                    spr_idx <= '0;
                    best_d  <= '1;
                    err_q   <= 1'b0;
                    loc_q   <= '0;
                    state   <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (fault_hit) begin
                        flt_idx <= scan_k;
                        state   <= ST_DECODE;
                    end else if (scan_k == IDX_W'(NUM_PE)) begin
                        state <= ST_DONE;
                    end else begin
                        scan_k <= scan_k + 1'b1;
                    end
                end
                ST_DECODE: begin
                    fld_q  <= flt_fld_w;
                    scan_k <= IDX_W'(1);
                    state  <= ST_SELECT;
                end
                ST_SELECT: begin
                    if (take_cand) begin
                        spr_idx <= scan_k;
                        best_d  <= cur_d;
                    end
                    if (scan_k == IDX_W'(NUM_PE)) begin
                        if (take_cand || spr_idx != '0) begin
                            state <= ST_REWRITE;
                        end else begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end
                    end else begin
                        scan_k <= scan_k + 1'b1;
                    end
                end
                ST_REWRITE: begin
                    cfg_q          <= cfg_new;
                    act_q[spr_bit] <= 1'b1;
                    act_q[flt_bit] <= 1'b0;
                    loc_q          <= {s_row, s_col};
                    state          <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done_o      = (state == ST_DONE);
    assign err_o       = err_q;
    assign spare_loc_o = loc_q;
    assign cfg_o       = cfg_q;
    assign act_mask_o  = act_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R3
    spare_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REWRITE) |->
            (!act_q[spr_bit] && !flt_q[spr_bit] && spr_idx != flt_idx));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN || state == ST_DECODE || state == ST_SELECT ||
         state == ST_DONE) |=> $stable(cfg_o));

    // R8
    act_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o && spr_idx != '0) |->
            (act_mask_o[spr_bit] && !act_mask_o[flt_bit]));
endmodule

// File: tb/rmp_spare_ctrl_test.sv
`timescale 1ns/1ps
module rmp_spare_ctrl_test;
    localparam int N  = 25;
    localparam int FW = 13;
    localparam int CW = N * FW;
    localparam logic [N-1:0] EX_MASK = 25'b1001010011011110111011101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [N-1:0]  act_mask_i = '0;
    logic [N-1:0]  flt_mask_i = '0;
    logic [CW-1:0] cfg_i = '0;
    logic          done_o, err_o;
    logic [4:0]    spare_loc_o;
    logic [CW-1:0] cfg_o;
    logic [N-1:0]  act_mask_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    rmp_spare_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .act_mask_i(act_mask_i), .flt_mask_i(flt_mask_i), .cfg_i(cfg_i),
        .done_o(done_o), .err_o(err_o), .spare_loc_o(spare_loc_o),
        .cfg_o(cfg_o), .act_mask_o(act_mask_o));

    task automatic chk(input bit ok, input string req, input logic [CW-1:0] got,
                       input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [CW-1:0] rand_cfg();
        logic [CW-1:0] c;
        for (int k = 0; k < N; k++)
            c[k*FW +: FW] = {3'(rnd() % 8), 5'(rnd() % 26), 5'(rnd() % 26)};
        return c;
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // one run against the arithmetic model of R1..R10
    task automatic run_case(input logic [N-1:0] a, input logic [N-1:0] fl,
                            input logic [CW-1:0] c, input string tag);
        int f = 0, s = 0, bd = 99, d, cyc;
        logic [CW-1:0] ecfg;
        logic [N-1:0]  eact;
        logic [4:0]    eloc;
        logic          eerr;
        logic [FW-1:0] fld;
        for (int k = 1; k <= N; k++)
            if (a[N-k] && fl[N-k] && f == 0) f = k;               // R1 R2
        if (f != 0)
            for (int k = 1; k <= N; k++)
                if (!a[N-k] && !fl[N-k]) begin                    // R3
                    d = absd((k-1) % 4, (f-1) % 4) + absd((k-1) / 4, (f-1) / 4);
                    if (d < bd) begin bd = d; s = k; end
                end
        ecfg = c; eact = a; eloc = '0; eerr = 1'b0;
        if (f != 0 && s == 0) eerr = 1'b1;                        // R9
        if (s != 0) begin
            for (int k = 1; k <= N; k++) begin                    // R5 R6 R7
                fld = (k == s) ? c[(f-1)*FW +: FW] : c[(k-1)*FW +: FW];
                if (fld[9:5] == 5'(f)) fld[9:5] = 5'(s);
                if (fld[4:0] == 5'(f)) fld[4:0] = 5'(s);
                if (k == f) fld = '0;
                ecfg[(k-1)*FW +: FW] = fld;
            end
            eact[N-s] = 1'b1; eact[N-f] = 1'b0;                   // R8
            eloc = {2'((s-1) % 4), 3'((s-1) / 4)};                // R4
        end
        @(negedge clk);
        act_mask_i = a; flt_mask_i = fl; cfg_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
        chk(cyc < 200, {"R10 done timeout ", tag}, CW'(cyc), CW'(200));
        chk(err_o == eerr, {"R9 err ", tag}, CW'(err_o), CW'(eerr));
        chk(spare_loc_o == eloc, {"R4 spare_loc ", tag}, CW'(spare_loc_o), CW'(eloc));
        chk(cfg_o == ecfg, {"R7 cfg word ", tag}, cfg_o, ecfg);
        chk(act_mask_o == eact, {"R8 act mask ", tag}, CW'(act_mask_o), CW'(eact));
        @(negedge clk);
        chk(!done_o, {"R10 done pulse width ", tag}, CW'(done_o), CW'(0));
        chk(spare_loc_o == eloc && err_o == eerr && cfg_o == ecfg,
            {"R10 outputs hold ", tag}, CW'(spare_loc_o), CW'(eloc));
    endtask

    initial begin
        logic [CW-1:0] c;
        logic [N-1:0]  a, fl;
        repeat (3) @(negedge clk);
        chk(!done_o && !err_o && spare_loc_o == '0 && cfg_o == '0 && act_mask_o == '0,
            "R11 reset values", CW'(act_mask_o), CW'(0));
        rst_n = 1'b1;

        // example: element 10 faulty, element 11 expected as spare
        c = rand_cfg();
        c[9*FW +: FW] = {3'd5, 5'd3, 5'd0};
        c[16*FW +: FW] = {3'd1, 5'd10, 5'd10};
        run_case(EX_MASK, 25'(1) << (N - 10), c, "example pe10");
        chk(spare_loc_o == 5'b10_010, "R3 example spare is element 11",
            CW'(spare_loc_o), CW'(5'b10_010));
        chk(cfg_o[10*FW +: FW] == {3'd5, 5'd3, 5'd0}, "R5 spare takes setting",
            CW'(cfg_o[10*FW +: FW]), CW'({3'd5, 5'd3, 5'd0}));
        chk(cfg_o[9*FW +: FW] == '0, "R6 faulty field cleared",
            CW'(cfg_o[9*FW +: FW]), CW'(0));
        chk(cfg_o[16*FW +: FW] == {3'd1, 5'd11, 5'd11}, "R7 consumer redirected",
            CW'(cfg_o[16*FW +: FW]), CW'({3'd1, 5'd11, 5'd11}));
        chk(act_mask_o[N-11] && !act_mask_o[N-10], "R1 mask bit positions",
            CW'(act_mask_o), CW'(0));

        // single-fault sweep over every element (idle ones: R2 no change)
        for (int k = 1; k <= N; k++)
            run_case(EX_MASK, 25'(1) << (N - k), rand_cfg(), "sweep");

        // R3 tie: element 6 faulty, idle 2 and 7 both at distance 1 -> 2
        a = '1; a[N-2] = 1'b0; a[N-7] = 1'b0;
        run_case(a, 25'(1) << (N - 6), rand_cfg(), "tie");
        chk(spare_loc_o == 5'b01_000, "R3 tie goes to lower number",
            CW'(spare_loc_o), CW'(5'b01_000));

        // R3 faulty idle candidate is skipped
        run_case(EX_MASK, (25'(1) << (N - 10)) | (25'(1) << (N - 11)), rand_cfg(),
                 "faulty spare");
        // R2 lowest of two active faults handled
        run_case(EX_MASK, (25'(1) << (N - 21)) | (25'(1) << (N - 4)), rand_cfg(),
                 "two faults");
        // R2 no fault at all
        run_case(EX_MASK, '0, rand_cfg(), "no fault");
        // R9 fully busy array
        c = rand_cfg();
        run_case('1, 25'(1) << (N - 13), c, "all busy");
        chk(err_o && cfg_o == c, "R9 error leaves word", cfg_o, c);

        // pseudo-random masks and words
        for (int i = 0; i < 60; i++) begin
            a  = 25'(rnd()) | 25'(rnd());
            fl = (25'(1) << (rnd() % N)) | ((i % 3 == 0) ? 25'(1) << (rnd() % N) : '0);
            run_case(a, fl, rand_cfg(), "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule